// File: doc/BRIEF.md
# Memory Pattern Write/Read-Back Tester

This block is a bus host that exercises a word-addressed memory agent sitting in front of an external SDRAM. When started, it writes a short run of consecutive words with a counting pattern. It then reads the same run back and compares every returned word against the value it wrote. At the end it reports a mismatch count, a done flag and a pass flag.

The bus uses wait-request flow control. The host presents a command and keeps it steady while the agent stalls. The command is taken on the first rising edge where wait-request is low, and the stall may last any number of cycles. Read data comes back on its own pipelined path and counts only when read-data-valid is high. Beats arrive in the order in which the reads were issued. The strobes and the byte enables are active low.

The block is meant for bring-up. Software or a switch pulses the start input, and the three result outputs can be wired straight to indicators or probed on a logic analyser.

Top module: `mem_pattern_tester`

## Requirements
- R1: After reset, and until the first start, both strobes are high (inactive), done and pass are low, and the error count is zero.
- R2: While a read or write strobe is low and wait-request is high, the address, write data, byte enables and both strobes keep their values on the next cycle. A command counts as accepted on the first rising edge with wait-request low.
- R3: While a strobe is low, chip select is high and the 2-bit active-low byte enable is 2'b00.
- R4: The read strobe and the write strobe are never low together. Both are high whenever no command is pending, including after done.
- R5: The write phase issues exactly NUM_WORDS writes to addresses 0, 1, ..., NUM_WORDS-1 in ascending order. The word written to address k carries k in bits [7:0] and zero in bits [15:8].
- R6: No read is issued before the last write has been accepted. The read phase issues exactly NUM_WORDS reads to the same addresses in ascending order.
- R7: Read data is taken only on cycles where read-data-valid is high and at least one read is outstanding. Beats are matched to reads in issue order. A read-data-valid beat with no read outstanding has no effect on the error count or on done.
- R8: Each returned word that differs from the value written to its address adds one to a saturating error count. Done rises on the edge that takes the last expected beat. Pass is high exactly when done is high and the error count is zero.
- R9: Start acts only when no pass is in progress, and then it clears done and the error count. A start pulse during a pass is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin one write-then-read pass |
| addr_o | output | 25 | Word address of the current command |
| wdata_o | output | 16 | Write data |
| be_no | output | 2 | Byte enables, active low |
| cs_o | output | 1 | Chip select |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| waitreq_i | input | 1 | Agent stall; command must be held while high |
| rdata_i | input | 16 | Returned read data |
| rdvalid_i | input | 1 | Returned read data is valid this cycle |
| done_o | output | 1 | Pass finished |
| pass_o | output | 1 | Finished with no mismatch |
| err_cnt_o | output | 8 | Saturating mismatch count |

## Verification
The bench's agent model stalls each command for zero cycles, for random lengths up to seven cycles, or for a long fixed stall, and it returns reads after random latencies. A host that moved its address or data during a stall would store the pattern at the wrong location, or the bench would see the command change under the stall. A host that advanced on a stalled edge would skip an address. The model flips bit 8 in chosen read words and checks that the error count equals the number of corrupted beats. This catches a host that paired beats with the wrong expected value or counted beats that arrived with no read pending. Stray valid beats sent while idle and after done, and a start pulse sent in mid-pass, check that neither one disturbs the result nor starts a second run of writes.

// File: rtl/mpt_pkg.sv
package mpt_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2,
    PH_DRAIN = 2'd3
  } phase_e;

  // pattern word for a given index: index kept in the low pat_w bits
  function automatic logic [31:0] pat_of(logic [31:0] idx, int unsigned pat_w);
    return idx & ((32'd1 << pat_w) - 32'd1);
  endfunction

endpackage

// File: rtl/mpt_cmd_issuer.sv
module mpt_cmd_issuer
  import mpt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 25,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned PAT_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              waitreq_i,
  input  logic              drained_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              rd_acc_o,
  output logic              clear_o
);

  localparam int unsigned IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  phase_e           ph_q;
  logic [IDX_W-1:0] idx_q;
  logic             accept;

  // command outputs come only from registered state, so they cannot move during a stall
  assign wr_no    = (ph_q != PH_WRITE);
  assign rd_no    = (ph_q != PH_READ);
  assign addr_o   = ADDR_W'(idx_q);
  assign wdata_o  = DATA_W'(pat_of(32'(idx_q), PAT_W));
  assign accept   = !waitreq_i && (ph_q == PH_WRITE || ph_q == PH_READ);
  assign rd_acc_o = accept && (ph_q == PH_READ);
  assign clear_o  = start_i && (ph_q == PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      idx_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (start_i) begin
            ph_q  <= PH_WRITE;
            idx_q <= '0;
          end
        end
        PH_WRITE: begin
          if (accept) begin
            if (idx_q == LAST_IDX) begin
              ph_q  <= PH_READ;
              idx_q <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        PH_READ: begin
          if (accept) begin
            if (idx_q == LAST_IDX) begin
              ph_q  <= PH_DRAIN;
              idx_q <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        PH_DRAIN: begin
          if (drained_i) ph_q <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mpt_rd_tracker.sv
module mpt_rd_tracker
  import mpt_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned PAT_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              rd_acc_i,
  input  logic              rdvalid_i,
  output logic              beat_o,
  output logic              last_o,
  output logic [DATA_W-1:0] exp_o
);

  localparam int unsigned IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int unsigned OUT_W = $clog2(NUM_WORDS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  logic [OUT_W-1:0] outst_q;
  logic [IDX_W-1:0] rx_q;

  assign beat_o = rdvalid_i && (outst_q != '0);
  assign last_o = beat_o && (rx_q == LAST_IDX);
  assign exp_o  = DATA_W'(pat_of(32'(rx_q), PAT_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outst_q <= '0;
      rx_q    <= '0;
    end else if (clear_i) begin
      outst_q <= '0;
      rx_q    <= '0;
    end else begin
      unique case ({rd_acc_i, beat_o})
        2'b10:   outst_q <= outst_q + 1'b1;
        2'b01:   outst_q <= outst_q - 1'b1;
        default: outst_q <= outst_q;
      endcase
      if (beat_o) rx_q <= (rx_q == LAST_IDX) ? '0 : rx_q + 1'b1;
    end
  end

endmodule

// File: rtl/mpt_result_checker.sv
module mpt_result_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ERR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              beat_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] exp_i,
  output logic [ERR_W-1:0]  err_o,
  output logic              done_o
);

  logic mismatch;
  assign mismatch = beat_i && (rdata_i != exp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o  <= '0;
      done_o <= 1'b0;
    end else if (clear_i) begin
      err_o  <= '0;
      done_o <= 1'b0;
    end else begin
      if (mismatch && err_o != '1) err_o <= err_o + 1'b1;
      if (last_i) done_o <= 1'b1;
    end
  end

endmodule

// File: rtl/mem_pattern_tester.sv
module mem_pattern_tester #(
  parameter int unsigned ADDR_W    = 25,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BE_W      = 2,
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned PAT_W     = 8,
  parameter int unsigned ERR_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [BE_W-1:0]   be_no,
  output logic              cs_o,
  output logic              rd_no,
  output logic              wr_no,
  input  logic              waitreq_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              rdvalid_i,
  output logic              done_o,
  output logic              pass_o,
  output logic [ERR_W-1:0]  err_cnt_o
);

  logic              rd_acc;
  logic              clear;
  logic              beat;
  logic              last;
  logic [DATA_W-1:0] exp_word;

  assign cs_o   = 1'b1;
  assign be_no  = '0;
  assign pass_o = done_o && (err_cnt_o == '0);

  mpt_cmd_issuer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .PAT_W(PAT_W)
  ) u_issuer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .waitreq_i(waitreq_i),
    .drained_i(last), .addr_o(addr_o), .wdata_o(wdata_o), .rd_no(rd_no),
    .wr_no(wr_no), .rd_acc_o(rd_acc), .clear_o(clear)
  );

  mpt_rd_tracker #(
    .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .PAT_W(PAT_W)
  ) u_tracker (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .rd_acc_i(rd_acc),
    .rdvalid_i(rdvalid_i), .beat_o(beat), .last_o(last), .exp_o(exp_word)
  );

  mpt_result_checker #(
    .DATA_W(DATA_W), .ERR_W(ERR_W)
  ) u_result (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .beat_i(beat),
    .last_i(last), .rdata_i(rdata_i), .exp_i(exp_word), .err_o(err_cnt_o),
    .done_o(done_o)
  );

endmodule

// File: rtl/mpt_checker.sv
module mpt_checker #(
  parameter int unsigned ADDR_W    = 25,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BE_W      = 2,
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned ERR_W     = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DATA_W-1:0] wdata_o,
  input logic [BE_W-1:0]   be_no,
  input logic              cs_o,
  input logic              rd_no,
  input logic              wr_no,
  input logic              waitreq_i,
  input logic              done_o,
  input logic              pass_o,
  input logic [ERR_W-1:0]  err_cnt_o
);

  logic cmd;
  assign cmd = !rd_no || !wr_no;

  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd && waitreq_i |=> $stable(addr_o) && $stable(wdata_o) && $stable(be_no)
                         && $stable(rd_no) && $stable(wr_no)); // R2

  AST_CS_BE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd |-> cs_o && (be_no == '0)); // R3

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_no || wr_no); // R4

  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rd_no && wr_no); // R4

  AST_ADDR_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd |-> (32'(addr_o) < NUM_WORDS)); // R5

  AST_PASS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> done_o && (err_cnt_o == '0)); // R8

  AST_ERR_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && (err_cnt_o == '1) |=> (err_cnt_o == '1)); // R8

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && rd_no && wr_no && done_o |=> !done_o && (err_cnt_o == '0)); // R9

endmodule

bind mem_pattern_tester mpt_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .NUM_WORDS(NUM_WORDS), .ERR_W(ERR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_o(addr_o),
  .wdata_o(wdata_o), .be_no(be_no), .cs_o(cs_o), .rd_no(rd_no), .wr_no(wr_no),
  .waitreq_i(waitreq_i), .done_o(done_o), .pass_o(pass_o), .err_cnt_o(err_cnt_o)
);

// File: tb/mem_pattern_tester_bench.sv
module mem_pattern_tester_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [24:0] addr_o;
  logic [15:0] wdata_o;
  logic [1:0]  be_no;
  logic        cs_o, rd_no, wr_no;
  logic        waitreq_i = 1'b0;
  logic [15:0] rdata_i = 16'h0;
  logic        rdvalid_i = 1'b0;
  logic        done_o, pass_o;
  logic [7:0]  err_cnt_o;

  mem_pattern_tester u_mem_pattern_tester (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_o(addr_o),
    .wdata_o(wdata_o), .be_no(be_no), .cs_o(cs_o), .rd_no(rd_no), .wr_no(wr_no),
    .waitreq_i(waitreq_i), .rdata_i(rdata_i), .rdvalid_i(rdvalid_i),
    .done_o(done_o), .pass_o(pass_o), .err_cnt_o(err_cnt_o)
  );

  always #4 clk_i = ~clk_i;

  int n_chk = 0;
  int n_fail = 0;

  // agent model state
  int          cyc = 0;
  int          stall_mode = 0;   // 0 random 0..7, 1 none, 2 fixed long
  logic [7:0]  cmask = '0;       // reads of these addresses come back corrupted
  int          stray_n = 0;
  bit          in_cmd = 0;
  int          stall = 0;
  logic [44:0] snap;
  logic [15:0] mem [8];
  int          q_time [16];
  logic [15:0] q_dat [16];
  int          q_head = 0, q_tail = 0, last_ret = 0;
  int          wr_count = 0, rd_count = 0, ret_count = 0;
  int          hold_viol = 0, csbe_viol = 0, strobe_viol = 0, order_viol = 0, done_viol = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pattern(input int k);
    return 16'(k & 8'hFF);
  endfunction

  always @(negedge clk_i) begin
    cyc++;
    if (!rst_ni) begin
      waitreq_i = 1'b0;
      rdvalid_i = 1'b0;
      in_cmd    = 0;
    end else begin
      if (!rd_no && !wr_no) strobe_viol++;
      if (done_o && !start_i && ret_count != 8) done_viol++;
      if (!rd_no || !wr_no) begin
        if (!cs_o || be_no != 2'b00) csbe_viol++;
        if (!in_cmd) begin
          in_cmd = 1;
          snap   = {addr_o, wdata_o, be_no, rd_no, wr_no};
          stall  = (stall_mode == 1) ? 0 : (stall_mode == 2) ? 15 : int'($urandom % 8);
        end else if ({addr_o, wdata_o, be_no, rd_no, wr_no} != snap) begin
          hold_viol++;
        end
        if (stall > 0) begin
          waitreq_i = 1'b1;
          stall--;
        end else begin
          waitreq_i = 1'b0;
          in_cmd    = 0;
          if (addr_o >= 25'd8) order_viol++;
          else if (!wr_no) begin
            if (int'(addr_o) != wr_count || rd_count != 0) order_viol++;
            mem[addr_o[2:0]] = wdata_o;
            wr_count++;
          end else begin
            if (wr_count != 8 || int'(addr_o) != rd_count) order_viol++;
            q_dat[q_tail % 16] = mem[addr_o[2:0]] ^ (cmask[addr_o[2:0]] ? 16'h0100 : 16'h0);
            last_ret = ((cyc + 1 + ((stall_mode == 1) ? 0 : int'($urandom % 6))) > last_ret + 1)
                     ? (cyc + 1 + ((stall_mode == 1) ? 0 : int'($urandom % 6))) : last_ret + 1;
            q_time[q_tail % 16] = last_ret;
            q_tail++;
            rd_count++;
          end
        end
      end else begin
        waitreq_i = 1'b0;
        in_cmd    = 0;
      end
      if (q_head != q_tail && q_time[q_head % 16] <= cyc) begin
        rdvalid_i = 1'b1;
        rdata_i   = q_dat[q_head % 16];
        q_head++;
        ret_count++;
      end else if (stray_n > 0) begin
        rdvalid_i = 1'b1;
        rdata_i   = 16'hBEEF;
        stray_n--;
      end else begin
        rdvalid_i = 1'b0;
        rdata_i   = 16'($urandom);
      end
    end
  end

  task automatic run_pass(input int mode, input logic [7:0] mask, input bit poke);
    int wait_c;
    @(posedge clk_i); #1;
    stall_mode = mode;
    cmask      = mask;
    wr_count = 0; rd_count = 0; ret_count = 0;
    hold_viol = 0; csbe_viol = 0; strobe_viol = 0; order_viol = 0; done_viol = 0;
    for (int k = 0; k < 8; k++) mem[k] = 16'hFFFF;
    start_i = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    check(!done_o && err_cnt_o == 0, "R9 start clears done/err", {done_o, err_cnt_o}, 0);
    if (poke) begin
      repeat (6) @(posedge clk_i);
      #1 start_i = 1'b1;
      @(posedge clk_i); #1;
      start_i = 1'b0;
    end
    wait_c = 0;
    while (!done_o && wait_c < 4000) begin
      @(posedge clk_i); #1;
      wait_c++;
    end
    check(done_o == 1'b1, "R8 done raised", done_o, 1);
    @(negedge clk_i); #1;
    check(err_cnt_o == 8'($countones(mask)), "R8 error count", err_cnt_o, $countones(mask));
    check(pass_o == (mask == 0), "R8 pass flag", pass_o, (mask == 0));
    check(wr_count == 8, "R5 write count", wr_count, 8);
    check(rd_count == 8, "R6 read count", rd_count, 8);
    for (int k = 0; k < 8; k++)
      check(mem[k] == pattern(k), "R5 stored pattern", mem[k], pattern(k));
    check(hold_viol == 0, "R2 command held during stall", hold_viol, 0);
    check(csbe_viol == 0, "R3 chip select and byte enables", csbe_viol, 0);
    check(strobe_viol == 0, "R4 single strobe", strobe_viol, 0);
    check(rd_no && wr_no, "R4 strobes idle after done", {rd_no, wr_no}, 3);
    check(order_viol == 0, "R6 address order and phase split", order_viol, 0);
    check(done_viol == 0, "R8 done only after last beat", done_viol, 0);
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "R8 watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (4) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i); #1;
    // R1: reset state
    check(rd_no && wr_no, "R1 strobes idle after reset", {rd_no, wr_no}, 3);
    check(!done_o && !pass_o, "R1 done/pass low after reset", {done_o, pass_o}, 0);
    check(err_cnt_o == 0, "R1 error count zero", err_cnt_o, 0);
    // R7: stray beats while idle
    @(posedge clk_i); #1 stray_n = 3;
    repeat (6) @(posedge clk_i);
    #1;
    check(err_cnt_o == 0 && !done_o, "R7 stray beat while idle ignored", err_cnt_o, 0);
    check(rd_no && wr_no, "R1 still idle without start", {rd_no, wr_no}, 3);
    // directed: no stalls, clean memory
    run_pass(1, 8'h00, 0);
    // random stalls, corrupted reads, start poked mid-pass (R9)
    run_pass(0, 8'h24, 1);
    // R7: stray beat after done
    @(posedge clk_i); #1 stray_n = 2;
    repeat (5) @(posedge clk_i);
    #1;
    check(err_cnt_o == 2 && done_o, "R7 stray beat after done ignored", err_cnt_o, 2);
    // long stalls, first and last words corrupted
    run_pass(2, 8'h81, 0);
    // all words corrupted, no stalls
    run_pass(1, 8'hFF, 0);
    // random passes
    for (int i = 0; i < 4; i++) run_pass(0, 8'($urandom), (i % 2) == 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule